// File: doc/BRIEF.md
# Page-Table Address Translator with Reference Bits

This block converts 16-bit virtual addresses into 16-bit physical addresses through a single-level table of sixteen page entries, with 4 KiB pages. The top four bits of a virtual address pick one entry. That entry's 4-bit frame number replaces those four bits, and the 12-bit byte offset passes through untouched. Every entry also carries a valid flag and an "accessed" flag. A lookup through a valid entry sets that entry's accessed flag. A lookup through an invalid entry instead reports a fault.

Software, or a controlling state machine, loads entries through a write port. It inspects any entry through a combinational read-back port. It can sweep all accessed flags back to zero with a single clear pulse. Sampling and clearing those flags at intervals gives a page-replacement policy a cheap approximation of recency.

Top module: `page_xlate_top`

## Requirements
- R1: For a request through a valid entry, `xl_paddr` equals that entry's frame number in bits 15:12, joined with `xl_vaddr[11:0]` unchanged in bits 11:0. The entry is selected by `xl_vaddr[15:12]`.
- R2: `xl_done` is high in exactly the cycle after each cycle in which `xl_req` is high, and low otherwise. `xl_paddr` and `xl_fault` are valid in that cycle. Back-to-back requests give back-to-back results.
- R3: A request through an entry whose valid flag is 0 gives `xl_fault` = 1 and `xl_paddr` = 0, and it leaves that entry's accessed flag unchanged. A request through a valid entry gives `xl_fault` = 0.
- R4: A request through a valid entry sets that entry's accessed flag to 1, and the flag reads 1 from the next cycle on. No other entry's flag changes.
- R5: A `ref_clear` pulse zeroes the accessed flags of all sixteen entries in the next cycle. Frame numbers and valid flags are left as they were.
- R6: If `ref_clear` and a request through a valid entry fall in the same cycle, that entry's accessed flag reads 1 afterwards. Every other flag reads 0.
- R7: A write (`wr_en`) stores `wr_frame` and `wr_valid` into entry `wr_idx` and zeroes its accessed flag. A request in the same cycle still uses the old contents. Requests from the next cycle on use the new ones.
- R8: If a write and a request hit the same entry in the same cycle, the write wins and the entry's accessed flag reads 0 afterwards.
- R9: After reset, every entry is invalid with accessed flag 0, and `xl_done` is 0.
- R10: `rd_frame`, `rd_valid` and `rd_ref` show the current contents of entry `rd_idx` in the same cycle, with no register in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| xl_req | input | 1 | Translation request, one per cycle while high |
| xl_vaddr | input | 16 | Virtual address of the request |
| xl_done | output | 1 | Result strobe, one cycle after the request |
| xl_paddr | output | 16 | Physical address, 0 on a fault |
| xl_fault | output | 1 | The selected entry was invalid |
| wr_en | input | 1 | Load one table entry |
| wr_idx | input | 4 | Entry to load |
| wr_frame | input | 4 | Frame number to store |
| wr_valid | input | 1 | Valid flag to store |
| ref_clear | input | 1 | Zero all accessed flags |
| rd_idx | input | 4 | Entry to inspect |
| rd_frame | output | 4 | Frame number of the inspected entry |
| rd_valid | output | 1 | Valid flag of the inspected entry |
| rd_ref | output | 1 | Accessed flag of the inspected entry |

## Verification
A translation result is due one clock edge after its request. The bench drives each request on a falling edge and samples `xl_done`, `xl_paddr` and `xl_fault` on the next falling edge, just after the single result register has loaded. Table writes, clears and flag updates also take effect at that one edge, so entry state is read back over the combinational port from the falling edge after the operation on. The read happens a short settle delay after `rd_idx` is changed. The checker properties use the same one-edge spacing (`|=>`) and stand down whenever `rd_idx` moves between cycles.

// File: rtl/pt_pkg.sv
// Package for the page-table translator.
// Holds the default geometry and the per-entry update action encoding.
// Assumes: the frame field and the page index are each at least one bit wide.
package pt_pkg;

    localparam int DEF_VA_W  = 16;
    localparam int DEF_PA_W  = 16;
    localparam int DEF_OFF_W = 12;

    // Update chosen for one table entry in one cycle
    typedef enum logic [1:0] {
        UPD_HOLD = 2'd0,   // keep everything
        UPD_LOAD = 2'd1,   // write port reloads frame/valid, drops accessed flag
        UPD_MARK = 2'd2,   // translation sets the accessed flag
        UPD_WIPE = 2'd3    // bulk clear drops the accessed flag
    } pte_upd_e;

    // Priority: load over mark over wipe
    function automatic pte_upd_e pick_upd(input logic load, input logic mark, input logic wipe);
        if (load)      return UPD_LOAD;
        else if (mark) return UPD_MARK;
        else if (wipe) return UPD_WIPE;
        else           return UPD_HOLD;
    endfunction

endpackage

// File: rtl/pt_entry_store.sv
// Storage for all page table entries: frame number, valid flag, accessed flag.
// Each entry is updated on its own by the action picked from the write port,
// the translator's mark vector and the bulk clear.
// Assumes: at most one write per cycle, and a mark vector that is onehot0.
module pt_entry_store
    import pt_pkg::*;
#(
    parameter int N_ENT   = 16,
    parameter int IDX_W   = 4,
    parameter int FRAME_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [FRAME_W-1:0]              wr_frame,
    input  logic                            wr_valid,
    input  logic [N_ENT-1:0]                mark_vec,
    input  logic                            wipe,
    output logic [N_ENT-1:0][FRAME_W-1:0]   frame_tbl,
    output logic [N_ENT-1:0]                valid_tbl,
    output logic [N_ENT-1:0]                ref_tbl
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        logic     load_g;
        pte_upd_e act_g;

        // Decode whether the write port targets this entry and pick the action
        always_comb begin
            load_g = wr_en && (wr_idx == IDX_W'(g));
            act_g  = pick_upd(load_g, mark_vec[g], wipe);
        end

        // Apply the chosen action to this entry's fields
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                frame_tbl[g] <= '0;
                valid_tbl[g] <= 1'b0;
                ref_tbl[g]   <= 1'b0;
            end else begin
                case (act_g)
                    UPD_LOAD: begin
                        frame_tbl[g] <= wr_frame;
                        valid_tbl[g] <= wr_valid;
                        ref_tbl[g]   <= 1'b0;
                    end
                    UPD_MARK: ref_tbl[g] <= 1'b1;
                    UPD_WIPE: ref_tbl[g] <= 1'b0;
                    default:  ref_tbl[g] <= ref_tbl[g];
                endcase
            end
        end
    end

endmodule

// File: rtl/pt_lookup.sv
// Translation path: splits the virtual address, selects the entry, builds the
// physical address and registers the result one cycle after the request.
// It also drives the one-hot mark vector that sets the accessed flag.
// Assumes: PA_W == FRAME_W + OFF_W, and the table contents seen are the pre-edge values.
module pt_lookup #(
    parameter int VA_W    = 16,
    parameter int PA_W    = 16,
    parameter int OFF_W   = 12,
    parameter int N_ENT   = 16,
    parameter int IDX_W   = 4,
    parameter int FRAME_W = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req,
    input  logic [VA_W-1:0]                 vaddr,
    input  logic [N_ENT-1:0][FRAME_W-1:0]   frame_tbl,
    input  logic [N_ENT-1:0]                valid_tbl,
    output logic [N_ENT-1:0]                mark_vec,
    output logic                            done,
    output logic [PA_W-1:0]                 paddr,
    output logic                            fault
);

    logic [IDX_W-1:0]   page_idx;
    logic [OFF_W-1:0]   page_off;
    logic [FRAME_W-1:0] sel_frame;
    logic               sel_valid;

    // Split the address and read the selected entry
    always_comb begin
        page_idx  = vaddr[VA_W-1:OFF_W];
        page_off  = vaddr[OFF_W-1:0];
        sel_frame = frame_tbl[page_idx];
        sel_valid = valid_tbl[page_idx];
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_mark
        // Flag the entry a successful translation touches
        assign mark_vec[g] = req && sel_valid && (page_idx == IDX_W'(g));
    end

    // Register the translation outcome and the done strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done  <= 1'b0;
            paddr <= '0;
            fault <= 1'b0;
        end else begin
            done <= req;
            if (req) begin
                fault <= !sel_valid;
                paddr <= sel_valid ? {sel_frame, page_off} : '0;
            end
        end
    end

endmodule

// File: rtl/pt_readback.sv
// Combinational inspection port: returns the fields of one selected entry.
// Assumes: the index is always in range (N_ENT == 2**IDX_W).
module pt_readback #(
    parameter int N_ENT   = 16,
    parameter int IDX_W   = 4,
    parameter int FRAME_W = 4
) (
    input  logic [IDX_W-1:0]                idx,
    input  logic [N_ENT-1:0][FRAME_W-1:0]   frame_tbl,
    input  logic [N_ENT-1:0]                valid_tbl,
    input  logic [N_ENT-1:0]                ref_tbl,
    output logic [FRAME_W-1:0]              frame,
    output logic                            valid,
    output logic                            refd
);

    // Mux the selected entry onto the read-back outputs
    always_comb begin
        frame = frame_tbl[idx];
        valid = valid_tbl[idx];
        refd  = ref_tbl[idx];
    end

endmodule

// File: rtl/page_xlate_top.sv
// Page-table translator top: a single-level table of 2**(VA_W-OFF_W) entries
// with a write port, a bulk clear of accessed flags, a registered translation
// path and a combinational read-back port.
// Assumes: synchronous active-low reset, and PA_W > OFF_W.
module page_xlate_top
    import pt_pkg::*;
#(
    parameter int VA_W  = DEF_VA_W,
    parameter int PA_W  = DEF_PA_W,
    parameter int OFF_W = DEF_OFF_W,
    localparam int IDX_W   = VA_W - OFF_W,
    localparam int N_ENT   = 1 << IDX_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               xl_req,
    input  logic [VA_W-1:0]    xl_vaddr,
    output logic               xl_done,
    output logic [PA_W-1:0]    xl_paddr,
    output logic               xl_fault,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_valid,
    input  logic               ref_clear,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [FRAME_W-1:0] rd_frame,
    output logic               rd_valid,
    output logic               rd_ref
);

    logic [N_ENT-1:0][FRAME_W-1:0] frame_tbl;
    logic [N_ENT-1:0]              valid_tbl;
    logic [N_ENT-1:0]              ref_tbl;
    logic [N_ENT-1:0]              mark_vec;

    pt_entry_store #(
        .N_ENT  (N_ENT),
        .IDX_W  (IDX_W),
        .FRAME_W(FRAME_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_frame (wr_frame),
        .wr_valid (wr_valid),
        .mark_vec (mark_vec),
        .wipe     (ref_clear),
        .frame_tbl(frame_tbl),
        .valid_tbl(valid_tbl),
        .ref_tbl  (ref_tbl)
    );

    pt_lookup #(
        .VA_W   (VA_W),
        .PA_W   (PA_W),
        .OFF_W  (OFF_W),
        .N_ENT  (N_ENT),
        .IDX_W  (IDX_W),
        .FRAME_W(FRAME_W)
    ) u_lookup (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (xl_req),
        .vaddr    (xl_vaddr),
        .frame_tbl(frame_tbl),
        .valid_tbl(valid_tbl),
        .mark_vec (mark_vec),
        .done     (xl_done),
        .paddr    (xl_paddr),
        .fault    (xl_fault)
    );

    pt_readback #(
        .N_ENT  (N_ENT),
        .IDX_W  (IDX_W),
        .FRAME_W(FRAME_W)
    ) u_rd (
        .idx      (rd_idx),
        .frame_tbl(frame_tbl),
        .valid_tbl(valid_tbl),
        .ref_tbl  (ref_tbl),
        .frame    (rd_frame),
        .valid    (rd_valid),
        .refd     (rd_ref)
    );

endmodule

// File: rtl/pt_checker.sv
// Port-level properties of the page-table translator, bound to its top.
// Assumes: the same parameter values as the bound instance.
module pt_checker #(
    parameter int VA_W  = 16,
    parameter int PA_W  = 16,
    parameter int OFF_W = 12,
    localparam int IDX_W   = VA_W - OFF_W,
    localparam int FRAME_W = PA_W - OFF_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               xl_req,
    input logic [VA_W-1:0]    xl_vaddr,
    input logic               xl_done,
    input logic [PA_W-1:0]    xl_paddr,
    input logic               xl_fault,
    input logic               wr_en,
    input logic [IDX_W-1:0]   wr_idx,
    input logic [FRAME_W-1:0] wr_frame,
    input logic               wr_valid,
    input logic               ref_clear,
    input logic [IDX_W-1:0]   rd_idx,
    input logic [FRAME_W-1:0] rd_frame,
    input logic               rd_valid,
    input logic               rd_ref
);

    p_done_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> xl_done);

    p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_req |=> !xl_done);

    p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (xl_fault || xl_paddr[OFF_W-1:0] == $past(xl_vaddr[OFF_W-1:0])));

    p_fault_zero_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done && xl_fault) |-> (xl_paddr == '0));

    p_invalid_keeps_ref_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !rd_valid && !rd_ref && !wr_en && rd_idx == xl_vaddr[VA_W-1:OFF_W])
        |=> (!$stable(rd_idx) || !rd_ref));

    // Also covers the R6 case, where a clear in the same cycle must lose
    p_touch_sets_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && rd_valid && rd_idx == xl_vaddr[VA_W-1:OFF_W] && !(wr_en && wr_idx == rd_idx))
        |=> (!$stable(rd_idx) || rd_ref));

    p_clear_drops_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_clear && !xl_req && !wr_en) |=> (!$stable(rd_idx) || !rd_ref));

    // Also covers R8: the write beats a same-cycle translation
    p_write_loads_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == rd_idx)
        |=> (!$stable(rd_idx) || (!rd_ref && rd_valid == $past(wr_valid) && rd_frame == $past(wr_frame))));

endmodule

bind page_xlate_top pt_checker #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .OFF_W(OFF_W)
) u_pt_checker (.*);

// File: tb/test_page_xlate_top.sv
module test_page_xlate_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xl_req = 1'b0;
    logic [15:0] xl_vaddr = '0;
    logic        xl_done;
    logic [15:0] xl_paddr;
    logic        xl_fault;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [3:0]  wr_frame = '0;
    logic        wr_valid = 1'b0;
    logic        ref_clear = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [3:0]  rd_frame;
    logic        rd_valid;
    logic        rd_ref;

    int n_chk = 0;
    int n_fail = 0;

    logic [3:0] m_frame [16];
    logic       m_valid [16];
    logic       m_ref   [16];

    always #10 clk = ~clk;

    page_xlate_top i_page_xlate_top (
        .clk(clk), .rst_n(rst_n),
        .xl_req(xl_req), .xl_vaddr(xl_vaddr),
        .xl_done(xl_done), .xl_paddr(xl_paddr), .xl_fault(xl_fault),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_frame(wr_frame), .wr_valid(wr_valid),
        .ref_clear(ref_clear),
        .rd_idx(rd_idx), .rd_frame(rd_frame), .rd_valid(rd_valid), .rd_ref(rd_ref)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R10: compare one entry's read-back with the model
    task automatic check_entry(input int i, input string req);
        rd_idx = 4'(i);
        #1;
        chk(rd_frame == m_frame[i], {req, " frame"}, 32'(rd_frame), 32'(m_frame[i]));
        chk(rd_valid == m_valid[i], {req, " valid"}, 32'(rd_valid), 32'(m_valid[i]));
        chk(rd_ref == m_ref[i], {req, " ref"}, 32'(rd_ref), 32'(m_ref[i]));
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < 16; i++) check_entry(i, req);
    endtask

    task automatic do_write(input int i, input logic [3:0] f, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(i); wr_frame = f; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
        m_frame[i] = f; m_valid[i] = v; m_ref[i] = 1'b0;
    endtask

    task automatic check_result(input logic [15:0] va, input string req);
        int i = int'(va[15:12]);
        logic [15:0] exp_pa = m_valid[i] ? {m_frame[i], va[11:0]} : 16'h0;
        chk(xl_done == 1'b1, {req, " done"}, 32'(xl_done), 32'd1);
        chk(xl_fault == !m_valid[i], {req, " fault"}, 32'(xl_fault), 32'(!m_valid[i]));
        chk(xl_paddr == exp_pa, {req, " paddr"}, 32'(xl_paddr), 32'(exp_pa));
    endtask

    task automatic do_xlate(input logic [15:0] va, input string req);
        @(negedge clk);
        xl_req = 1'b1; xl_vaddr = va;
        @(negedge clk);
        xl_req = 1'b0;
        check_result(va, req);
        if (m_valid[va[15:12]]) m_ref[va[15:12]] = 1'b1;
    endtask

    initial begin
        #(20 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_frame[i] = '0; m_valid[i] = 1'b0; m_ref[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R9: reset state
        chk(xl_done == 1'b0, "R9 done", 32'(xl_done), 32'd0);
        check_all("R9");

        // R1/R4: the worked mapping
        do_write(14, 4'd3, 1'b1);
        do_write(3, 4'd10, 1'b1);
        do_write(10, 4'd5, 1'b1);
        do_write(7, 4'd15, 1'b1);
        do_xlate(16'hE12C, "R1 E12C");
        chk(xl_paddr == 16'h312C, "R1 E12C literal", 32'(xl_paddr), 32'h312C);
        do_xlate(16'h3A9D, "R1 3A9D");
        chk(xl_paddr == 16'hAA9D, "R1 3A9D literal", 32'(xl_paddr), 32'hAA9D);
        do_xlate(16'hA9D9, "R1 A9D9");
        do_xlate(16'h7001, "R1 7001");
        chk(xl_paddr == 16'hF001, "R1 7001 literal", 32'(xl_paddr), 32'hF001);
        do_xlate(16'hACA1, "R1 ACA1");
        chk(xl_paddr == 16'h5CA1, "R1 ACA1 literal", 32'(xl_paddr), 32'h5CA1);
        check_all("R4");

        // R3: invalid entry faults and keeps its flag
        do_xlate(16'h5123, "R3 invalid");
        check_entry(5, "R3");

        // R5: bulk clear
        @(negedge clk); ref_clear = 1'b1;
        @(negedge clk); ref_clear = 1'b0;
        for (int i = 0; i < 16; i++) m_ref[i] = 1'b0;
        check_all("R5");

        // R1/R3 sweep over every entry and several offsets
        for (int i = 0; i < 16; i++) do_write(i, 4'((i * 5 + 9) % 16), (i % 4) != 2);
        for (int i = 0; i < 16; i++) begin
            do_xlate({4'(i), 12'h000}, "R1 sweep lo");
            do_xlate({4'(i), 12'hFFF}, "R1 sweep hi");
            do_xlate({4'(i), 12'h5A3}, "R3 sweep mid");
        end
        check_all("R3 sweep");

        // R2: back-to-back requests, then idle
        @(negedge clk); ref_clear = 1'b1;
        @(negedge clk); ref_clear = 1'b0;
        for (int i = 0; i < 16; i++) m_ref[i] = 1'b0;
        @(negedge clk); xl_req = 1'b1; xl_vaddr = 16'h1234;
        @(negedge clk); check_result(16'h1234, "R2 first"); xl_vaddr = 16'h2FED;
        @(negedge clk); check_result(16'h2FED, "R2 second"); xl_req = 1'b0;
        m_ref[1] = 1'b1;
        @(negedge clk);
        chk(xl_done == 1'b0, "R2 idle", 32'(xl_done), 32'd0);
        check_all("R2 flags");

        // R6: clear and touch in the same cycle
        @(negedge clk); ref_clear = 1'b1; xl_req = 1'b1; xl_vaddr = 16'h3000;
        @(negedge clk); ref_clear = 1'b0; xl_req = 1'b0;
        check_result(16'h3000, "R6");
        for (int i = 0; i < 16; i++) m_ref[i] = 1'b0;
        m_ref[3] = 1'b1;
        check_all("R6");

        // R7/R8: write and translate the same entry in the same cycle
        do_xlate(16'h7ABC, "R8 pre");
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'd7; wr_frame = 4'd2; wr_valid = 1'b1;
        xl_req = 1'b1; xl_vaddr = 16'h7456;
        @(negedge clk);
        wr_en = 1'b0; xl_req = 1'b0;
        check_result(16'h7456, "R7 old contents");
        m_frame[7] = 4'd2; m_valid[7] = 1'b1; m_ref[7] = 1'b0;
        check_entry(7, "R8");
        do_xlate(16'h7456, "R7 new contents");
        chk(xl_paddr == 16'h2456, "R7 literal", 32'(xl_paddr), 32'h2456);

        // R7: invalidating an entry makes the next lookup fault
        do_write(14, 4'd3, 1'b0);
        do_xlate(16'hE12C, "R7 invalidated");
        check_all("R7 final");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule